// File: doc/BRIEF.md
# Access Permission and Reference/Change Update Unit

This block sits behind a radix table walker. It takes the leaf entry the walker found, the kind of access (read, write or instruction fetch), whether the requester runs in problem (user) state, and a three-bit permission set derived from the authority mask register. From these it decides whether the access may proceed.

When the access is granted, the block produces an updated entry with the referenced bit set, and with the changed bit set for stores. It raises a write-back request only when that update actually alters the entry. It also produces the permission set to install in the translation cache. A non-store access never installs write permission, so a later store comes back through this unit and sets the changed bit. When the access is refused, the block builds the status for a storage interrupt. A data access gets a data cause word, with a store flag for writes, and the faulting address is captured. An instruction fetch gets an instruction cause word instead.

The decision is combinational. It is captured into a registered response stage that is controlled by a small state machine. The machine has three states. `S_IDLE` means there is no response. `S_GRANT` means the response is valid and the access is allowed. `S_FAULT` means the response is valid and the access is refused. Each cycle the machine takes one of three transitions: to `S_GRANT` on a request that passes, to `S_FAULT` on a request that fails, and to `S_IDLE` when no request is present. Any state can take any of these transitions.

Top module: `rc_perm_unit`

## Requirements
- R1: If the entry's attribute field (bits 5:4) holds 2'b10 (non-idempotent I/O) and the access is an execute, the access faults with only the guard cause (bit 1) in the instruction cause word. No permission check contributes to that cause.
- R2: If the entry's privileged-only bit (bit 3) is set and the request is in problem state, the granted permission set is empty, so every access faults with the protection cause.
- R3: In problem state, or for a privileged-only page, the permission set comes from the entry alone. Read is bit 2 OR bit 1, write is bit 1, and execute is bit 0. The mask input has no effect in this case.
- R4: In supervisor state on a page without the privileged-only bit, the permission set is the entry's set ANDed with `req_amr_perm`. Permission sets use bit 0 for read, bit 1 for write and bit 2 for execute.
- R5: Access codes are 0 read, 1 write, 2 execute, and 3 treated as read. If the permission the access needs is missing, the access faults with the protection cause (bit 0).
- R6: On a grant, the new entry equals the old entry with the referenced bit (bit 8) set, plus the changed bit (bit 7) for writes only. On a fault, the reported entry equals the input entry.
- R7: On a grant, the installed permissions equal the computed set, except that for non-write accesses the write bit is cleared. On a fault, the installed permissions are 0.
- R8: The write-back request is high only on a grant whose new entry differs from the input entry.
- R9: A fault on a non-execute access is a data fault. The data cause word is the fault cause ORed with the store flag (bit 2) when the access is a write. The fault address is loaded with the request address, and the instruction cause word is 0. On an execute fault, the instruction cause word carries the cause, the data cause word is 0, and the fault address keeps its previous value.
- R10: The response is valid exactly one cycle after a cycle with `req_valid` high, and at no other time. After reset, the response is not valid and the fault address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_pte | input | PTE_W | Leaf entry to judge |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_problem | input | 1 | Requester is in problem state |
| req_amr_perm | input | 3 | Mask-derived permissions {exec, write, read} |
| req_eaddr | input | ADDR_W | Effective address of the access |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_prot | output | 3 | Permissions to install {exec, write, read} |
| rsp_wb_req | output | 1 | Write back the updated entry |
| rsp_new_pte | output | PTE_W | Updated entry |
| rsp_data_fault | output | 1 | Refused access was a data access |
| rsp_data_cause | output | CAUSE_W | Data storage cause word |
| rsp_fault_addr | output | ADDR_W | Address of the last data fault |
| rsp_instr_cause | output | CAUSE_W | Instruction storage cause word |

## Verification
The guard fault and the protection check can both apply in the same cycle. This happens when an execute access hits an I/O-attributed page that also lacks execute permission. Directed cases provoke this overlap, and about a quarter of the random entries force the I/O attribute. The check requires that only the guard cause appears. A second overlap is the store flag together with the protection cause on a refused write. This overlap is judged by exact comparison of the data cause word against a bench model.

// File: rtl/rcperm_pkg.sv
package rcperm_pkg;
    // Access kinds
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Response state machine
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GRANT = 2'd1,
        S_FAULT = 2'd2
    } rsp_state_e;

    // Entry field positions
    localparam int unsigned EXEC_BIT = 0;
    localparam int unsigned RW_BIT   = 1;
    localparam int unsigned RD_BIT   = 2;
    localparam int unsigned PRIV_BIT = 3;
    localparam int unsigned ATTR_LO  = 4;
    localparam int unsigned CHG_BIT  = 7;
    localparam int unsigned REF_BIT  = 8;
    localparam logic [1:0]  ATTR_NIIO = 2'b10;

    // Permission set positions
    localparam int unsigned P_RD = 0;
    localparam int unsigned P_WR = 1;
    localparam int unsigned P_EX = 2;

    // Cause word positions
    localparam int unsigned C_PROT  = 0;
    localparam int unsigned C_GUARD = 1;
    localparam int unsigned C_STORE = 2;
endpackage

// File: rtl/rcperm_decode.sv
module rcperm_decode
    import rcperm_pkg::*;
(
    input  logic [3:0] auth_bits,   // {priv, rd, rw, exec}
    input  logic       problem,
    input  logic [2:0] amr_perm,
    output logic [2:0] perm
);
    logic [2:0] auth;
    logic       priv;

    always_comb begin
        priv       = auth_bits[PRIV_BIT];
        auth[P_RD] = auth_bits[RD_BIT] | auth_bits[RW_BIT];
        auth[P_WR] = auth_bits[RW_BIT];
        auth[P_EX] = auth_bits[EXEC_BIT];
        if (priv && problem)
            perm = 3'b000;
        else if (priv || problem)
            perm = auth;
        else
            perm = auth & amr_perm;
    end
endmodule

// File: rtl/rcperm_judge.sv
module rcperm_judge
    import rcperm_pkg::*;
#(
    parameter int unsigned CAUSE_W = 32
) (
    input  logic [1:0]         access,
    input  logic [1:0]         attr,
    input  logic [2:0]         perm,
    output logic               allow,
    output logic [CAUSE_W-1:0] cause
);
    logic [2:0] need;
    logic       guard;

    always_comb begin
        unique case (access)
            ACC_WRITE: need = 3'b010;
            ACC_EXEC:  need = 3'b100;
            default:   need = 3'b001;
        endcase
        guard = (attr == ATTR_NIIO) && (access == ACC_EXEC);
        cause = '0;
        allow = 1'b0;
        if (guard)
            cause[C_GUARD] = 1'b1;
        else if ((need & ~perm) != 3'b000)
            cause[C_PROT] = 1'b1;
        else
            allow = 1'b1;
    end
endmodule

// File: rtl/rcperm_rc.sv
module rcperm_rc
    import rcperm_pkg::*;
#(
    parameter int unsigned PTE_W = 64
) (
    input  logic [PTE_W-1:0] old_pte,
    input  logic             is_write,
    output logic [PTE_W-1:0] new_pte,
    output logic             changed
);
    always_comb begin
        new_pte          = old_pte;
        new_pte[REF_BIT] = 1'b1;
        if (is_write)
            new_pte[CHG_BIT] = 1'b1;
        changed = (new_pte != old_pte);
    end
endmodule

// File: rtl/rc_perm_unit.sv
module rc_perm_unit
    import rcperm_pkg::*;
#(
    parameter int unsigned PTE_W   = 64,
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PTE_W-1:0]   req_pte,
    input  logic [1:0]         req_access,
    input  logic               req_problem,
    input  logic [2:0]         req_amr_perm,
    input  logic [ADDR_W-1:0]  req_eaddr,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic [2:0]         rsp_prot,
    output logic               rsp_wb_req,
    output logic [PTE_W-1:0]   rsp_new_pte,
    output logic               rsp_data_fault,
    output logic [CAUSE_W-1:0] rsp_data_cause,
    output logic [ADDR_W-1:0]  rsp_fault_addr,
    output logic [CAUSE_W-1:0] rsp_instr_cause
);
    rsp_state_e state_q, state_d;

    logic [2:0]         perm;
    logic               allow;
    logic [CAUSE_W-1:0] cause;
    logic [PTE_W-1:0]   upd_pte;
    logic               upd_changed;
    logic               is_write, is_exec;

    assign is_write = (req_access == ACC_WRITE);
    assign is_exec  = (req_access == ACC_EXEC);

    rcperm_decode u_decode (
        .auth_bits ({req_pte[PRIV_BIT], req_pte[RD_BIT], req_pte[RW_BIT], req_pte[EXEC_BIT]}),
        .problem   (req_problem),
        .amr_perm  (req_amr_perm),
        .perm      (perm)
    );

    rcperm_judge #(.CAUSE_W(CAUSE_W)) u_judge (
        .access (req_access),
        .attr   (req_pte[ATTR_LO+1:ATTR_LO]),
        .perm   (perm),
        .allow  (allow),
        .cause  (cause)
    );

    rcperm_rc #(.PTE_W(PTE_W)) u_rc (
        .old_pte  (req_pte),
        .is_write (is_write),
        .new_pte  (upd_pte),
        .changed  (upd_changed)
    );

    // Next-state selection
    always_comb begin
        if (!req_valid)
            state_d = S_IDLE;
        else if (allow)
            state_d = S_GRANT;
        else
            state_d = S_FAULT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        unique case (state_q)
            S_GRANT: begin rsp_valid = 1'b1; rsp_grant = 1'b1; end
            S_FAULT: begin rsp_valid = 1'b1; rsp_grant = 1'b0; end
            default: begin rsp_valid = 1'b0; rsp_grant = 1'b0; end
        endcase
    end

    // Registered response payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_prot        <= '0;
            rsp_wb_req      <= 1'b0;
            rsp_new_pte     <= '0;
            rsp_data_fault  <= 1'b0;
            rsp_data_cause  <= '0;
            rsp_fault_addr  <= '0;
            rsp_instr_cause <= '0;
        end else if (req_valid) begin
            if (allow) begin
                rsp_prot        <= is_write ? perm : (perm & 3'b101);
                rsp_wb_req      <= upd_changed;
                rsp_new_pte     <= upd_pte;
                rsp_data_fault  <= 1'b0;
                rsp_data_cause  <= '0;
                rsp_instr_cause <= '0;
            end else begin
                rsp_prot        <= '0;
                rsp_wb_req      <= 1'b0;
                rsp_new_pte     <= req_pte;
                rsp_data_fault  <= !is_exec;
                if (is_exec) begin
                    rsp_data_cause  <= '0;
                    rsp_instr_cause <= cause;
                end else begin
                    rsp_data_cause  <= is_write ? (cause | (CAUSE_W'(1) << C_STORE)) : cause;
                    rsp_instr_cause <= '0;
                    rsp_fault_addr  <= req_eaddr;
                end
            end
        end else begin
            rsp_wb_req <= 1'b0;
        end
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_REF_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> rsp_new_pte[REF_BIT]); // R6
    AST_FAULT_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (rsp_prot == 3'b000)); // R7
    AST_WB_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb_req |-> (rsp_valid && rsp_grant)); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_data_fault) |-> $stable(rsp_fault_addr)); // R9
    AST_GUARD_IS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_instr_cause[C_GUARD] |-> (!rsp_data_fault && !rsp_instr_cause[C_PROT])); // R1
endmodule

// File: tb/rc_perm_unit_tb.sv
module rc_perm_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 64;
    localparam int AW = 64;
    localparam int CW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [PW-1:0] req_pte = '0;
    logic [1:0] req_access = '0;
    logic req_problem = 1'b0;
    logic [2:0] req_amr_perm = '0;
    logic [AW-1:0] req_eaddr = '0;
    logic rsp_valid, rsp_grant, rsp_wb_req, rsp_data_fault;
    logic [2:0] rsp_prot;
    logic [PW-1:0] rsp_new_pte;
    logic [CW-1:0] rsp_data_cause, rsp_instr_cause;
    logic [AW-1:0] rsp_fault_addr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [AW-1:0] exp_fa = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_perm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
        .req_access(req_access), .req_problem(req_problem), .req_amr_perm(req_amr_perm),
        .req_eaddr(req_eaddr), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_prot(rsp_prot), .rsp_wb_req(rsp_wb_req), .rsp_new_pte(rsp_new_pte),
        .rsp_data_fault(rsp_data_fault), .rsp_data_cause(rsp_data_cause),
        .rsp_fault_addr(rsp_fault_addr), .rsp_instr_cause(rsp_instr_cause)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements
    task automatic model(input logic [PW-1:0] pte, input logic [1:0] acc, input logic prob,
                         input logic [2:0] amr, output logic grant, output logic [2:0] prot,
                         output logic [PW-1:0] npte, output logic wb, output logic dfault,
                         output logic [CW-1:0] dcause, output logic [CW-1:0] icause);
        logic [2:0] auth, perm, need;
        logic [CW-1:0] cause;
        logic wr, ex;
        wr = (acc == 2'd1);
        ex = (acc == 2'd2);
        auth = {pte[0], pte[1], pte[2] | pte[1]};
        if (pte[3] && prob) perm = 3'b000;          // R2
        else if (pte[3] || prob) perm = auth;       // R3
        else perm = auth & amr;                     // R4
        need = wr ? 3'b010 : (ex ? 3'b100 : 3'b001);
        cause = '0;
        grant = 1'b0;
        if (pte[5:4] == 2'b10 && ex) cause = 32'h2;  // R1
        else if ((need & ~perm) != 0) cause = 32'h1; // R5
        else grant = 1'b1;
        npte = pte; wb = 0; prot = 0; dfault = 0; dcause = 0; icause = 0;
        if (grant) begin
            npte[8] = 1'b1;
            if (wr) npte[7] = 1'b1;
            wb = (npte != pte);
            prot = wr ? perm : {perm[2], 1'b0, perm[0]};
        end else if (ex) begin
            icause = cause;
        end else begin
            dfault = 1'b1;
            dcause = cause | (wr ? 32'h4 : 32'h0);
        end
    endtask

    task automatic txn(input string tag, input logic [PW-1:0] pte, input logic [1:0] acc,
                       input logic prob, input logic [2:0] amr, input logic [AW-1:0] ea);
        logic g, wb, df;
        logic [2:0] pr;
        logic [PW-1:0] np;
        logic [CW-1:0] dc, ic;
        model(pte, acc, prob, amr, g, pr, np, wb, df, dc, ic);
        if (df) exp_fa = ea;
        req_valid = 1'b1; req_pte = pte; req_access = acc;
        req_problem = prob; req_amr_perm = amr; req_eaddr = ea;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10"}, "valid", 64'(rsp_valid), 64'd1);
        chk({tag, " R5"},  "grant", 64'(rsp_grant), 64'(g));
        chk({tag, " R7"},  "prot",  64'(rsp_prot), 64'(pr));
        chk({tag, " R6"},  "pte",   rsp_new_pte, np);
        chk({tag, " R8"},  "wb",    64'(rsp_wb_req), 64'(wb));
        chk({tag, " R9"},  "dfault", 64'(rsp_data_fault), 64'(df));
        chk({tag, " R9"},  "dcause", 64'(rsp_data_cause), 64'(dc));
        chk({tag, " R9"},  "icause", 64'(rsp_instr_cause), 64'(ic));
        chk({tag, " R9"},  "faddr", rsp_fault_addr, exp_fa);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 reset", "valid", 64'(rsp_valid), 64'd0);
        chk("R10 reset", "faddr", rsp_fault_addr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle", "valid", 64'(rsp_valid), 64'd0);

        // R1: I/O attribute execute with full permissions -> guard only
        txn("R1 guard", 64'h0000_0000_0000_0027, 2'd2, 1'b1, 3'b111, 64'hA000);
        // R1: guard and missing execute together -> guard only
        txn("R1 overlap", 64'h0000_0000_0000_0024, 2'd2, 1'b0, 3'b111, 64'hA100);
        // R1: I/O attribute read is unaffected
        txn("R1 ioread", 64'h0000_0000_0000_0024, 2'd0, 1'b1, 3'b000, 64'hA200);
        // R2: privileged page from problem state
        txn("R2 priv", 64'h0000_0000_0000_000F, 2'd0, 1'b1, 3'b111, 64'hB000);
        // R3: problem state ignores mask
        txn("R3 prob", 64'h0000_0000_0000_0002, 2'd1, 1'b1, 3'b000, 64'hC000);
        // R3: privileged page in supervisor ignores mask
        txn("R3 privsup", 64'h0000_0000_0000_000D, 2'd2, 1'b0, 3'b000, 64'hC100);
        // R4: mask removes write -> store protection fault with store flag
        txn("R4 mask", 64'h0000_0000_0000_0003, 2'd1, 1'b0, 3'b001, 64'hD000);
        // R4: mask allows read
        txn("R4 read", 64'h0000_0000_0000_0003, 2'd0, 1'b0, 3'b001, 64'hD100);
        // R5: code 3 behaves as read
        txn("R5 rsvd", 64'h0000_0000_0000_0004, 2'd3, 1'b1, 3'b000, 64'hE000);
        // R8: referenced already set, read -> no write-back
        txn("R8 nowb", 64'h0000_0000_0000_0104, 2'd0, 1'b1, 3'b000, 64'hE100);
        // R6: write on entry with both bits set -> no change
        txn("R6 wrset", 64'h0000_0000_0000_0182, 2'd1, 1'b1, 3'b000, 64'hE200);
        // R7: read of writable page drops write permission
        txn("R7 rdwr", 64'h0000_0000_0000_0003, 2'd0, 1'b1, 3'b000, 64'hE300);
        // R10: idle cycle gives no response
        @(negedge clk);
        chk("R10 gap", "valid", 64'(rsp_valid), 64'd0);

        for (int i = 0; i < 400; i++) begin
            logic [PW-1:0] p;
            p = {$urandom, $urandom};
            if (($urandom % 4) == 0) p[5:4] = 2'b10;
            if (($urandom % 3) == 0) p[8:7] = 2'b00;
            txn("rand", p, 2'($urandom), 1'($urandom), 3'($urandom), {$urandom, $urandom});
            if (($urandom % 8) == 0) begin
                @(negedge clk);
                chk("R10 rgap", "valid", 64'(rsp_valid), 64'd0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule